// File: doc/BRIEF.md
# Network Controller Interrupt Status and Mask Unit

This unit holds the interrupt status register of a network controller together with its enable mask. The transmit and receive engines report events as single-cycle pulses. Each pulse sets a sticky bit that stays set until software clears it by writing a one to it. The same status register also shows live process-state fields. These come straight from an input and are not stored.

Two summary bits are derived from the events that the mask enables. The normal summary covers routine completions. The abnormal summary covers errors and state changes. One registered, level-sensitive interrupt line is raised when an enabled summary is active. Software reaches both registers through one 32-bit read/write port, where a select bit picks the status register or the mask register. Reads are combinational.

Top module: `nic_irq_status`

## Requirements
- R1: After reset, with `procState` at zero, the status register reads 0xF000_0000, the mask register reads 0xF3FE_0000 and `irqOut` is low.
- R2: A pulse on any event bit of `evtPulse` sets that status bit on the next clock edge, and the bit stays set until cleared. The event bits are 0 to 14, 26 and 27. Pulses on any other position have no effect.
- R3: A status write (`regSel`=0) clears every event bit whose written data bit is 1 and leaves bits written as 0 unchanged. Written data has no effect on bits 17 to 25 or bits 28 to 31.
- R4: If an event pulse and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R5: Status bit 16 (normal summary) is 1 exactly when at least one of event bits 0, 2, 6, 11 or 14 is set and its mask bit is also set.
- R6: Status bit 15 (abnormal summary) is 1 exactly when at least one of event bits 1, 3, 4, 5, 7, 8, 9, 10, 12, 13, 26 or 27 is set and its mask bit is also set.
- R7: `irqOut` is a register. It is 1 exactly when (bit 16 AND mask bit 16) OR (bit 15 AND mask bit 15). It rises in the cycle that follows the enabling event pulse.
- R8: A mask write (`regSel`=1) stores all 32 bits, and the stored value reads back. From the next cycle on, both summaries and `irqOut` reflect the new mask.
- R9: Status bits 25:17 always show the current `procState[8:0]`, and status bits 31:28 always read as 1.
- R10: Writing a 1 to a summary bit does not clear that bit while an enabled event of its group is still set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 1 | Register select: 0 status, 1 mask |
| regWrEn | input | 1 | Write strobe for the selected register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the selected register (combinational) |
| evtPulse | input | 32 | Event pulses, one cycle each, at the status bit positions |
| procState | input | 9 | Live process-state fields shown in status bits 25:17 |
| irqOut | output | 1 | Level interrupt request |

## Verification
A wrong sticky bit shows up in the status read in the cycle after the offending pulse or write. If that bit is enabled, it also shows on `irqOut` in the same cycle. A summary computed from the wrong group, or from an event the mask does not enable, shows at the ports as soon as the event and mask combination occurs. For this reason the bench drives pulses on single bits into masks that enable one group at a time. A wrong mask register shows up both in the mask readback and in the interrupt line one cycle after the write.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
  localparam int REG_W     = 32;
  localparam int STATE_W   = 9;
  localparam int STATE_LSB = 17;
  localparam int AIS_BIT   = 15;
  localparam int NIS_BIT   = 16;
  localparam int TOP_LSB   = 28;

  // Routine-completion events feeding the normal summary
  localparam logic [REG_W-1:0] NORM_SET = 32'h0000_4845;
  // Error and state events feeding the abnormal summary
  localparam logic [REG_W-1:0] ABN_SET  = 32'h0C00_37BA;
  localparam logic [REG_W-1:0] EVT_SET  = NORM_SET | ABN_SET;

  localparam logic [REG_W-1:0] MASK_RST = 32'hF3FE_0000;

  typedef struct packed {
    logic wrStatus;
    logic wrMask;
    logic rdMask;
  } strobe_t;
endpackage

// File: rtl/nic_irq_ctrl.sv
module nic_irq_ctrl
  import nic_irq_pkg::*;
(
  input  logic    regSel,
  input  logic    regWrEn,
  output strobe_t stb
);
  always_comb begin
    stb.wrStatus = regWrEn & ~regSel;
    stb.wrMask   = regWrEn &  regSel;
    stb.rdMask   = regSel;
  end
endmodule

// File: rtl/nic_irq_datapath.sv
module nic_irq_datapath
  import nic_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [REG_W-1:0]   wrData,
  input  logic [REG_W-1:0]   evtPulse,
  input  logic [STATE_W-1:0] procState,
  output logic [REG_W-1:0]   rdData,
  output logic [REG_W-1:0]   evtQ,
  output logic [REG_W-1:0]   maskQ,
  output logic               nisQ,
  output logic               aisQ,
  output logic               irqQ
);
  logic [REG_W-1:0] clrBits, setBits, evtD, maskD, enD, statusView;
  logic nisD, aisD, irqD;

  always_comb begin
    clrBits = stb.wrStatus ? (wrData & EVT_SET) : '0;
    setBits = evtPulse & EVT_SET;
    evtD    = (evtQ & ~clrBits) | setBits;
    maskD   = stb.wrMask ? wrData : maskQ;
    enD     = evtD & maskD;
    nisD    = |(enD & NORM_SET);
    aisD    = |(enD & ABN_SET);
    irqD    = (nisD & maskD[NIS_BIT]) | (aisD & maskD[AIS_BIT]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtQ  <= '0;
      maskQ <= MASK_RST;
      nisQ  <= 1'b0;
      aisQ  <= 1'b0;
      irqQ  <= 1'b0;
    end else begin
      evtQ  <= evtD;
      maskQ <= maskD;
      nisQ  <= nisD;
      aisQ  <= aisD;
      irqQ  <= irqD;
    end
  end

  always_comb begin
    statusView = evtQ & EVT_SET;
    statusView[REG_W-1:TOP_LSB] = '1;
    statusView[STATE_LSB +: STATE_W] = procState;
    statusView[NIS_BIT] = nisQ;
    statusView[AIS_BIT] = aisQ;
    rdData = stb.rdMask ? maskQ : statusView;
  end
endmodule

// File: rtl/nic_irq_status.sv
module nic_irq_status
  import nic_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regSel,
  input  logic               regWrEn,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  input  logic [REG_W-1:0]   evtPulse,
  input  logic [STATE_W-1:0] procState,
  output logic               irqOut
);
  strobe_t          stb;
  logic [REG_W-1:0] evtQ, maskQ;
  logic             nisQ, aisQ;

  nic_irq_ctrl u_ctrl (
    .regSel (regSel),
    .regWrEn(regWrEn),
    .stb    (stb)
  );

  nic_irq_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (regWrData),
    .evtPulse (evtPulse),
    .procState(procState),
    .rdData   (regRdData),
    .evtQ     (evtQ),
    .maskQ    (maskQ),
    .nisQ     (nisQ),
    .aisQ     (aisQ),
    .irqQ     (irqOut)
  );
endmodule

// File: rtl/nic_irq_status_chk.sv
module nic_irq_status_chk
  import nic_irq_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             regSel,
  input logic             regWrEn,
  input logic [REG_W-1:0] regWrData,
  input logic [REG_W-1:0] evtPulse,
  input logic [REG_W-1:0] evtQ,
  input logic [REG_W-1:0] maskQ,
  input logic             nisQ,
  input logic             aisQ,
  input logic             irqOut
);
  // R2 and R4: a pulse always leaves its bit set, whatever the write does
  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    ((evtPulse & EVT_SET) != '0) |=>
      ((evtQ & $past(evtPulse & EVT_SET)) == $past(evtPulse & EVT_SET)));

  // R2: without a status write, no sticky bit drops
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && !regSel) |=> ((evtQ & $past(evtQ)) == $past(evtQ)));

  // R3: a status write with no pulse clears the written ones
  a_r3_w1c: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regSel && evtPulse == '0) |=>
      ((evtQ & $past(regWrData & EVT_SET)) == '0));

  // R5: normal summary only with an enabled normal event
  a_r5_nis_source: assert property (@(posedge clk) disable iff (!rstN)
    nisQ |-> ((evtQ & maskQ & NORM_SET) != '0));

  // R6: abnormal summary only with an enabled abnormal event
  a_r6_ais_source: assert property (@(posedge clk) disable iff (!rstN)
    aisQ |-> ((evtQ & maskQ & ABN_SET) != '0));

  // R7: no interrupt while both summary enables are off
  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (maskQ[AIS_BIT] || maskQ[NIS_BIT]));

  // R8: mask write lands in the mask register
  a_r8_mask_store: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel) |=> (maskQ == $past(regWrData)));
endmodule

bind nic_irq_status nic_irq_status_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regSel   (regSel),
  .regWrEn  (regWrEn),
  .regWrData(regWrData),
  .evtPulse (evtPulse),
  .evtQ     (evtQ),
  .maskQ    (maskQ),
  .nisQ     (nisQ),
  .aisQ     (aisQ),
  .irqOut   (irqOut)
);

// File: tb/sim_nic_irq_status.sv
`timescale 1ns/1ps
module sim_nic_irq_status;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regSel = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] evtPulse = '0;
  logic [8:0]  procState = '0;
  logic        irqOut;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nic_irq_status u0 (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .evtPulse(evtPulse),
    .procState(procState), .irqOut(irqOut)
  );

  // Behavioural reference model
  bit [31:0] mStat;
  bit [31:0] mMask = 32'hF3FE_0000;
  bit        mIrq;
  bit        mNis, mAis;

  function automatic bit isNormal(int b);
    return (b == 0 || b == 2 || b == 6 || b == 11 || b == 14);
  endfunction
  function automatic bit isAbnormal(int b);
    return (b == 1 || b == 3 || b == 4 || b == 5 || b == 7 || b == 8 || b == 9 ||
            b == 10 || b == 12 || b == 13 || b == 26 || b == 27);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mStat = '0; mMask = 32'hF3FE_0000; mIrq = 0; mNis = 0; mAis = 0;
    end else begin
      for (int b = 0; b < 32; b++) begin
        if (isNormal(b) || isAbnormal(b)) begin
          if (evtPulse[b]) mStat[b] = 1'b1;
          else if (regWrEn && !regSel && regWrData[b]) mStat[b] = 1'b0;
        end
      end
      if (regWrEn && regSel) mMask = regWrData;
      mNis = 0; mAis = 0;
      for (int b = 0; b < 32; b++) begin
        if (mStat[b] && mMask[b] && isNormal(b)) mNis = 1;
        if (mStat[b] && mMask[b] && isAbnormal(b)) mAis = 1;
      end
      mIrq = (mNis && mMask[16]) || (mAis && mMask[15]);
    end
  end

  function automatic bit [31:0] expStatus();
    bit [31:0] v;
    v = mStat;
    v[31:28] = 4'hF;
    v[25:17] = procState;
    v[16] = mNis;
    v[15] = mAis;
    return v;
  endfunction

  task automatic check(string req, bit [31:0] act, bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Drive one cycle of stimulus, then read back the chosen register
  task automatic step(string req, bit [31:0] pulse, bit wr, bit sel,
                      bit [31:0] data, bit rdSel);
    @(negedge clk);
    evtPulse = pulse; regWrEn = wr; regSel = sel; regWrData = data;
    @(negedge clk);
    evtPulse = '0; regWrEn = 0; regSel = rdSel; regWrData = '0;
    #1;
    check(req, regRdData, rdSel ? mMask : expStatus());
    check({req, " irq"}, {31'b0, irqOut}, {31'b0, mIrq});
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    check("R1 status reset", regRdData, 32'hF000_0000);
    check("R1 irq reset", {31'b0, irqOut}, 32'h0);
    regSel = 1; #1;
    check("R1 mask reset", regRdData, 32'hF3FE_0000);

    // R2 receive complete, not enabled: sticky bit, no summary
    step("R2 rx complete set", 32'h40, 0, 0, 0, 0);
    check("R5 no summary while disabled", regRdData[16], 1'b0);
    step("R2 non-event pulse ignored", 32'hF03F_8000, 0, 0, 0, 0);
    // R8 enable bit 6 and bit 16
    step("R8 mask write", 0, 1, 1, 32'h0001_0040, 1);
    step("R5 normal summary", 0, 0, 0, 0, 0);
    check("R7 irq raised", {31'b0, irqOut}, 32'h1);
    // R10 summary write-one while pending
    step("R10 summary persists", 0, 1, 0, 32'h0001_0000, 0);
    check("R10 bit16 still set", regRdData[16], 1'b1);
    // R3 clear
    step("R3 w1c rx complete", 0, 1, 0, 32'h0000_0040, 0);
    check("R3 irq dropped", {31'b0, irqOut}, 32'h0);
    step("R3 fields ignore writes", 32'h1, 1, 0, 32'hFFFE_0000, 0);
    // R4 collision on bit 0
    step("R4 event beats clear", 32'h1, 1, 0, 32'h1, 0);
    check("R4 bit0 stays", regRdData[0], 1'b1);
    // R6 abnormal: bus error bit 13 with mask bits 13 and 15
    step("R6 mask abnormal", 0, 1, 1, 32'h0000_A000, 1);
    step("R6 bus error", 32'h2000, 0, 0, 0, 0);
    check("R6 bit15 set", regRdData[15], 1'b1);
    check("R7 irq abnormal", {31'b0, irqOut}, 32'h1);
    step("R6 link changed", 32'h0800_0000, 0, 0, 0, 0);
    // R7 summary active but its enable off
    step("R7 enable without summary bit", 0, 1, 1, 32'h0000_2004, 1);
    step("R7 tx unavail", 32'h4, 0, 0, 0, 0);
    check("R7 no irq", {31'b0, irqOut}, 32'h0);
    check("R5 summary visible", regRdData[16], 1'b1);
    // R9 pass-through
    procState = 9'h1A5;
    step("R9 state visible", 0, 0, 0, 0, 0);
    check("R9 field", {23'b0, regRdData[25:17]}, 32'h1A5);
    procState = 9'h05A;
    #1;
    check("R9 live", {23'b0, regRdData[25:17]}, 32'h05A);
    step("R3 clear all", 0, 1, 0, 32'hFFFF_FFFF, 0);

    // Random traffic compared against the model
    for (int n = 0; n < 400; n++) begin
      bit [31:0] p;
      bit [31:0] d;
      p = ($urandom_range(0, 3) == 0) ? (32'h1 << $urandom_range(0, 31)) : 32'h0;
      d = $urandom;
      procState = 9'($urandom);
      step("R2-random", p, ($urandom_range(0, 2) == 0), $urandom_range(0, 1), d,
           $urandom_range(0, 1));
    end
    // Tag mention for random coverage: R2 R3 R5 R6 R7 R8
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule